// File: doc/BRIEF.md
# Chipset Configuration Registers and Upper-Memory Decoder

This block gives the CPU a small window into the chipset configuration through two I/O ports. One port holds a register number and the other reads or writes the register that number points to. Four registers sit behind that pair:
- a clock/wait control register, which feeds the CPU clock divider and the I/O wait-state logic;
- a RAM enable mask;
- a ROM enable mask;
- a fixed version byte.

The two masks steer the memory chip selects for the second SRAM and the flash ROM. The region from C0000h to FFFFFh is cut into eight 32 KiB windows, and each window can be given to SRAM or to ROM. The block decodes A19..A15 together with the memory strobes and drives both selects active low. The 80000h..9FFFFh region always belongs to the second SRAM. Read data leaves the block on a bus with its own output enable.

Top module: `cfg_memdec`

## Requirements
- R1: After reset the index is 00h, the clock/wait register reads 09h (divide-by-3 on, wait count 4), the RAM mask reads 00h and the ROM mask reads C0h (only the F0000h and F8000h windows are enabled).
- R2: A write with `idx_sel` loads the index, and an index-port read returns it. Data-port reads and writes act on the register the index names: 0 is clock/wait, 1 is the RAM mask, 2 is the ROM mask, 3 is the version.
- R3: Index 3 reads {major,minor} (10h by default), and writes to it are ignored. Every index of 4 or above reads FFh, and writes to it change nothing.
- R4: In the clock/wait register, bit 0 is the divide-by-3 select (`turbo_div3`) and bits 3:1 are the I/O wait count (`io_wait`). Bits 7:4 read as 0. A written wait count above 4 is stored as 4.
- R5: `ram2_cs_n` goes low for 80000h..9FFFFh (A19..A17 = 100) whatever the masks hold.
- R6: When A19 = A18 = 1, the window number is {A17,A16,A15}, with window 0 at C0000h and window 7 at F8000h. RAM mask bit w enables `ram2_cs_n` in window w.
- R7: ROM mask bit w enables `rom_cs_n` in window w and keeps `ram2_cs_n` high there, even when the RAM bit is also set.
- R8: Neither select goes low unless `mem_rd` or `mem_wr` is high. Neither goes low below 80000h or in A0000h..BFFFFh.
- R9: `rd_oe` is high only while `io_rd` is high and one of the two ports is selected. `rd_data` is 00h whenever `rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| idx_sel | input | 1 | Index port decoded |
| dat_sel | input | 1 | Data port decoded |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| wr_data | input | 8 | Write data from the bus |
| rd_data | output | 8 | Read data to the bus |
| rd_oe | output | 1 | Read data output enable |
| addr_hi | input | 5 | Address bits A19..A15 |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| ram2_cs_n | output | 1 | Second SRAM select, active low |
| rom_cs_n | output | 1 | Flash ROM select, active low |
| turbo_div3 | output | 1 | Clock divider select, 1 = divide by 3 |
| io_wait | output | 3 | I/O wait state count, 0 to 4 |

## Verification
The assertions assume the I/O and memory strobes are synchronous to `clk` and settle away from its edge. They also assume `idx_sel` and `dat_sel` are never both high in a write cycle. The bench drives every input on the falling edge, selects one port per access, and changes the masks only while both memory strobes are low. Decode vectors are applied only after the masks they need have been written through the ports.

// File: rtl/cfg_memdec_pkg.sv
package cfg_memdec_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] IDX_CLKWAIT = 8'd0;
   localparam logic [BYTE_W-1:0] IDX_RAMEN   = 8'd1;
   localparam logic [BYTE_W-1:0] IDX_ROMEN   = 8'd2;
   localparam logic [BYTE_W-1:0] IDX_VERSION = 8'd3;
   localparam logic [BYTE_W-1:0] RD_UNUSED   = 8'hFF;
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfg_memdec_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int WAIT_W    = 3,
   parameter int WAIT_MAX  = 4,
   parameter bit WAIT_SAT  = 1'b1,
   parameter int VER_MAJOR = 1,
   parameter int VER_MINOR = 0,
   parameter logic [NUM_WIN-1:0] RAM_RST  = '0,
   parameter logic [NUM_WIN-1:0] ROM_RST  = 8'hC0,
   parameter bit                 DIV_RST  = 1'b1,
   parameter int                 WAIT_RST = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_sel,
   input  logic              dat_sel,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_oe,
   output logic [NUM_WIN-1:0] ram_en,
   output logic [NUM_WIN-1:0] rom_en,
   output logic              turbo_div3,
   output logic [WAIT_W-1:0] io_wait
);
   localparam logic [WAIT_W-1:0] WAIT_MAX_V = WAIT_W'(WAIT_MAX);
   localparam logic [WAIT_W-1:0] WAIT_RST_V = WAIT_W'(WAIT_RST);
   localparam logic [BYTE_W-1:0] VER_BYTE   = {4'(VER_MAJOR), 4'(VER_MINOR)};
   localparam int                PAD_W      = BYTE_W - 1 - WAIT_W;

   logic [BYTE_W-1:0]  index_q;
   logic               div_q;
   logic [WAIT_W-1:0]  wait_q;
   logic [NUM_WIN-1:0] ram_q;
   logic [NUM_WIN-1:0] rom_q;
   logic [WAIT_W-1:0]  wait_req;
   logic [WAIT_W-1:0]  wait_next;
   logic               dat_wr;

   assign wait_req = wr_data[WAIT_W:1];
   assign dat_wr   = io_wr && dat_sel;

   generate
      if (WAIT_SAT) begin : g_wait_sat
         assign wait_next = (wait_req > WAIT_MAX_V) ? WAIT_MAX_V : wait_req;
      end else begin : g_wait_keep
         assign wait_next = (wait_req > WAIT_MAX_V) ? wait_q : wait_req;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         div_q   <= DIV_RST;
         wait_q  <= WAIT_RST_V;
         ram_q   <= RAM_RST;
         rom_q   <= ROM_RST;
      end else begin
         if (io_wr && idx_sel) index_q <= wr_data;
         if (dat_wr) begin
            case (index_q)
               IDX_CLKWAIT: begin
                  div_q  <= wr_data[0];
                  wait_q <= wait_next;
               end
               IDX_RAMEN: ram_q <= wr_data[NUM_WIN-1:0];
               IDX_ROMEN: rom_q <= wr_data[NUM_WIN-1:0];
               default: ;
            endcase
         end
      end
   end

   logic [BYTE_W-1:0] reg_mux;
   always_comb begin
      case (index_q)
         IDX_CLKWAIT: reg_mux = {{PAD_W{1'b0}}, wait_q, div_q};
         IDX_RAMEN:   reg_mux = ram_q;
         IDX_ROMEN:   reg_mux = rom_q;
         IDX_VERSION: reg_mux = VER_BYTE;
         default:     reg_mux = RD_UNUSED;
      endcase
   end

   assign rd_oe      = io_rd && (idx_sel || dat_sel);
   assign rd_data    = !rd_oe ? '0 : (idx_sel ? index_q : reg_mux);
   assign ram_en     = ram_q;
   assign rom_en     = rom_q;
   assign turbo_div3 = div_q;
   assign io_wait    = wait_q;

   assert_wait_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      io_wait <= WAIT_MAX_V);
   assert_ram_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_wr |=> $stable(ram_en));
   assert_rom_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_wr |=> $stable(rom_en));
   assert_oe_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> io_rd);
endmodule

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
   parameter int NUM_WIN = 8,
   parameter int AHI_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AHI_W-1:0]   addr_hi,
   input  logic               mem_rd,
   input  logic               mem_wr,
   input  logic [NUM_WIN-1:0] ram_en,
   input  logic [NUM_WIN-1:0] rom_en,
   output logic               ram2_cs_n,
   output logic               rom_cs_n
);
   localparam int WIN_BITS = $clog2(NUM_WIN);

   logic               upper;
   logic               low_bank;
   logic               strobe;
   logic [NUM_WIN-1:0] ram_hit;
   logic [NUM_WIN-1:0] rom_hit;

   assign upper    = (addr_hi[AHI_W-1 -: 2] == 2'b11);
   assign low_bank = (addr_hi[AHI_W-1 -: 3] == 3'b100);
   assign strobe   = mem_rd || mem_wr;

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         logic in_win;
         assign in_win     = upper && (addr_hi[WIN_BITS-1:0] == WIN_BITS'(w));
         assign rom_hit[w] = in_win && rom_en[w];
         assign ram_hit[w] = in_win && ram_en[w] && !rom_en[w];
      end
   endgenerate

   assign ram2_cs_n = !(strobe && (low_bank || (|ram_hit)));
   assign rom_cs_n  = !(strobe && (|rom_hit));

   assert_cs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram2_cs_n && !rom_cs_n));
   assert_cs_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram2_cs_n || !rom_cs_n) |-> (mem_rd || mem_wr));
   assert_low_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && addr_hi[AHI_W-1 -: 3] == 3'b100) |-> !ram2_cs_n);
endmodule

// File: rtl/cfg_memdec.sv
module cfg_memdec
   import cfg_memdec_pkg::*;
#(
   parameter int NUM_WIN   = 8,
   parameter int WAIT_W    = 3,
   parameter int WAIT_MAX  = 4,
   parameter bit WAIT_SAT  = 1'b1,
   parameter int VER_MAJOR = 1,
   parameter int VER_MINOR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_sel,
   input  logic              dat_sel,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic              rd_oe,
   input  logic [4:0]        addr_hi,
   input  logic              mem_rd,
   input  logic              mem_wr,
   output logic              ram2_cs_n,
   output logic              rom_cs_n,
   output logic              turbo_div3,
   output logic [WAIT_W-1:0] io_wait
);
   localparam int AHI_W = 5;

   generate
      if (NUM_WIN != 8) begin : g_bad_win
         $error("NUM_WIN must be 8: eight windows span C0000h..FFFFFh");
      end
      if (WAIT_W + 1 > BYTE_W || WAIT_MAX >= (1 << WAIT_W)) begin : g_bad_wait
         $error("wait field does not fit");
      end
      if (VER_MAJOR > 15 || VER_MINOR > 15) begin : g_bad_ver
         $error("version nibbles out of range");
      end
   endgenerate

   logic [NUM_WIN-1:0] ram_en;
   logic [NUM_WIN-1:0] rom_en;

   cfg_regfile #(
      .NUM_WIN(NUM_WIN), .WAIT_W(WAIT_W), .WAIT_MAX(WAIT_MAX),
      .WAIT_SAT(WAIT_SAT), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .idx_sel(idx_sel), .dat_sel(dat_sel),
      .io_rd(io_rd), .io_wr(io_wr), .wr_data(wr_data), .rd_data(rd_data),
      .rd_oe(rd_oe), .ram_en(ram_en), .rom_en(rom_en),
      .turbo_div3(turbo_div3), .io_wait(io_wait)
   );

   cfg_win_decode #(.NUM_WIN(NUM_WIN), .AHI_W(AHI_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .ram_en(ram_en), .rom_en(rom_en),
      .ram2_cs_n(ram2_cs_n), .rom_cs_n(rom_cs_n)
   );

   assert_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> (rd_data == 8'h00));
endmodule

// File: tb/cfg_memdec_tb.sv
module cfg_memdec_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idx_sel = 1'b0, dat_sel = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_oe;
   logic [4:0] addr_hi = '0;
   logic       mem_rd = 1'b0, mem_wr = 1'b0;
   logic       ram2_cs_n, rom_cs_n, turbo_div3;
   logic [2:0] io_wait;
   int         n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   cfg_memdec u_dut (.*);

   // vector: ram[24:17] rom[16:9] addr_hi[8:4] {mem_wr,mem_rd}[3:2] exp_ram_n[1] exp_rom_n[0]
   localparam int NV = 14;
   localparam logic [24:0] VEC [NV] = '{
      {8'h00, 8'hC0, 5'b10000, 2'b01, 1'b0, 1'b1},  // R5 80000h
      {8'h00, 8'hC0, 5'b10011, 2'b01, 1'b0, 1'b1},  // R5 98000h
      {8'h00, 8'hC0, 5'b11110, 2'b01, 1'b1, 1'b0},  // R7 F0000h rom
      {8'h00, 8'hC0, 5'b11000, 2'b01, 1'b1, 1'b1},  // R6 C0000h off
      {8'h01, 8'hC0, 5'b11000, 2'b01, 1'b0, 1'b1},  // R6 C0000h ram
      {8'hFF, 8'hC0, 5'b11111, 2'b01, 1'b1, 1'b0},  // R7 F8000h rom wins
      {8'hFF, 8'hC0, 5'b11101, 2'b01, 1'b0, 1'b1},  // R6 E8000h ram
      {8'hFF, 8'hFF, 5'b11010, 2'b01, 1'b1, 1'b0},  // R7 D0000h rom wins
      {8'hFF, 8'hFF, 5'b10000, 2'b00, 1'b1, 1'b1},  // R8 no strobe
      {8'hFF, 8'h00, 5'b10100, 2'b01, 1'b1, 1'b1},  // R8 A0000h
      {8'hFF, 8'hFF, 5'b00111, 2'b10, 1'b1, 1'b1},  // R8 38000h
      {8'h80, 8'h00, 5'b11111, 2'b10, 1'b0, 1'b1},  // R6 F8000h ram write
      {8'h04, 8'h08, 5'b11010, 2'b01, 1'b0, 1'b1},  // R6 window 2
      {8'h04, 8'h08, 5'b11011, 2'b01, 1'b1, 1'b0}   // R7 window 3
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic port_wr(input bit to_idx, input logic [7:0] v);
      @(negedge clk);
      idx_sel = to_idx; dat_sel = !to_idx; io_wr = 1'b1; wr_data = v;
      @(negedge clk);
      idx_sel = 1'b0; dat_sel = 1'b0; io_wr = 1'b0; wr_data = '0;
   endtask

   task automatic port_rd(input bit from_idx, output logic [7:0] v, output logic oe);
      @(negedge clk);
      idx_sel = from_idx; dat_sel = !from_idx; io_rd = 1'b1;
      #1 v = rd_data; oe = rd_oe;
      @(negedge clk);
      idx_sel = 1'b0; dat_sel = 1'b0; io_rd = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
      logic oe;
      port_wr(1'b1, idx);
      port_rd(1'b0, v, oe);
   endtask

   task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
      port_wr(1'b1, idx);
      port_wr(1'b0, v);
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic       oe;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      port_rd(1'b1, v, oe);  chk("R1 index", v, 8'h00);
      chk("R1 div3", {7'b0, turbo_div3}, 8'h01);
      chk("R1 wait", {5'b0, io_wait}, 8'h04);
      reg_rd(8'd0, v);       chk("R1 clkwait", v, 8'h09);
      reg_rd(8'd1, v);       chk("R1 ram mask", v, 8'h00);
      reg_rd(8'd2, v);       chk("R1 rom mask", v, 8'hC0);
      // R9 output enable
      @(negedge clk); #1;
      chk("R9 oe idle", {7'b0, rd_oe}, 8'h00);
      chk("R9 data idle", rd_data, 8'h00);
      port_rd(1'b1, v, oe);  chk("R9 oe read", {7'b0, oe}, 8'h01);
      // R2 index readback
      port_wr(1'b1, 8'hA5);
      port_rd(1'b1, v, oe);  chk("R2 index readback", v, 8'hA5);
      // R3 version and unused indices
      reg_rd(8'd3, v);       chk("R3 version", v, 8'h10);
      reg_wr(8'd3, 8'h55);
      reg_rd(8'd3, v);       chk("R3 version write ignored", v, 8'h10);
      reg_wr(8'd7, 8'h12);
      reg_rd(8'd7, v);       chk("R3 unused idx 7", v, 8'hFF);
      reg_rd(8'd200, v);     chk("R3 unused idx 200", v, 8'hFF);
      reg_rd(8'd1, v);       chk("R3 ram unaffected", v, 8'h00);
      reg_rd(8'd2, v);       chk("R3 rom unaffected", v, 8'hC0);
      // R4 clock/wait register
      reg_wr(8'd0, 8'h06);
      reg_rd(8'd0, v);       chk("R4 clkwait 06", v, 8'h06);
      chk("R4 div3 off", {7'b0, turbo_div3}, 8'h00);
      chk("R4 wait 3", {5'b0, io_wait}, 8'h03);
      reg_wr(8'd0, 8'hFF);
      reg_rd(8'd0, v);       chk("R4 clamp read", v, 8'h09);
      chk("R4 clamp wait", {5'b0, io_wait}, 8'h04);
      reg_wr(8'd0, 8'h00);
      chk("R4 wait 0", {5'b0, io_wait}, 8'h00);
      // R2 data port reaches masks
      reg_wr(8'd1, 8'h3C);
      reg_rd(8'd1, v);       chk("R2 ram mask rw", v, 8'h3C);
      // R5..R8 decode table
      for (int i = 0; i < NV; i++) begin
         reg_wr(8'd1, VEC[i][24:17]);
         reg_wr(8'd2, VEC[i][16:9]);
         @(negedge clk);
         addr_hi = VEC[i][8:4];
         {mem_wr, mem_rd} = VEC[i][3:2];
         #1;
         chk($sformatf("R5-8 vec %0d cs", i), {6'b0, ram2_cs_n, rom_cs_n}, {6'b0, VEC[i][1:0]});
         @(negedge clk);
         mem_rd = 1'b0; mem_wr = 1'b0;
      end
      // R8 strobe removed keeps both high
      #1 chk("R8 idle selects", {6'b0, ram2_cs_n, rom_cs_n}, 8'h03);
      // R1 reset again restores masks
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      reg_rd(8'd2, v);       chk("R1 rom after reset", v, 8'hC0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule